// File: doc/BRIEF.md
# Inductive Charging Transmitter Phase Sequencer

This block is the control state machine on the transmitting side of an inductive charging pad. A packet decoder in front of it delivers receiver messages that are already framed. For each message the decoder gives the header byte, the extension flag of an identification message, the signed control-error byte, and a strobe. Two more flags mark the moment a start bit is detected and the moment a stop bit closes a message. A checksum-error flag travels with the strobe. The sequencer decides when the coil may be energised and which inverter frequency to command. It also removes power as soon as the receiver misbehaves.

It runs a short detection probe at a fixed cadence. When something answers the probe, it starts the ping, which applies the power signal at a fixed operating point. It then requires identification messages in a strict order. After that it regulates power transfer from control-error feedback until a timeout, an illegal message or a foreign-object warning ends it. Every timeout and delay is a parameter counted in clock cycles.

States and transitions:
- SEL_WAIT moves to SEL_PROBE when its gap count ends.
- SEL_PROBE moves to PING on a probe response, and back to SEL_WAIT when the probe length ends.
- PING moves to ID_FIRST on a signal-strength message.
- ID_FIRST moves to ID_EXT or ID_OPT, depending on the extension flag.
- ID_EXT moves to ID_OPT on an extended-identification message.
- ID_OPT moves to XFER on a configuration message.
- XFER moves to PING on a foreign-object warning.
- PING, ID_FIRST, ID_EXT, ID_OPT and XFER all move to OFF on an illegal message or an expired timeout.
- OFF moves to SEL_WAIT when the restart delay ends.

Top module: `wpt_phase_seq`

## Requirements
- R1: From reset, and after each restart, the block idles for PROBE_GAP cycles with power off, then raises probe_en for PROBE_LEN cycles, and repeats. probe_resp seen while probe_en is high enters ping, with power_en high. probe_en and power_en are never high together.
- R2: In ping, a good message with header 0x01 advances to identification. A good message with any other header drops power_en at the clock edge that samples it.
- R3: Identification requires header 0x71 first. If ext_flag is 1 with that message, header 0x81 must come next. Configuration header 0x51 then closes the phase. A good message that breaks this order drops power.
- R4: Between identification and configuration, up to MAX_OPT (7) optional messages are accepted. Optional headers are 0x06, 0x18, 0xF2, and reserved headers, meaning any header other than 0x01-0x06, 0x18, 0xF2, 0x51, 0x71 and 0x81. The next optional message after MAX_OPT drops power, as does any non-optional header other than 0x51.
- R5: freq_cmd equals F_PING (175) in every state except power transfer, including reset.
- R6: In power transfer, headers 0x02, 0x03, 0x04 and 0x05, the optional-message headers 0x18 and 0xF2, and reserved headers are accepted. Headers 0x01, 0x06, 0x51, 0x71 and 0x81 drop power.
- R7: In power transfer, power drops when CE_TMO cycles pass after the last control-error message (0x03) with no start bit pending. Power also drops when RP_TMO cycles pass after entry without a rectified-power message (0x04).
- R8: A good control-error message sets freq_cmd to the old value minus ce_value times F_STEP, where ce_value is signed 8-bit. The change appears SETTLE cycles after the message and is clamped to F_MIN..F_MAX (110..205).
- R9: foreign_obj during power transfer returns the block to ping: freq_cmd goes back to F_PING at once, power_en stays high, and header 0x01 is then accepted.
- R10: In ping and in the identification states, power drops when RESP_TMO cycles pass after phase entry or after the last stop bit with no start bit detected.
- R11: A message whose strobe arrives with chk_err high is ignored in every state.
- R12: After power is removed, the block stays off for RESTART cycles and then resumes the selection cadence of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| probe_resp | input | 1 | Receiver reaction to the detection probe |
| start_seen | input | 1 | Pulse: start bit of a message detected |
| stop_seen | input | 1 | Pulse: stop bit of a message detected |
| msg_valid | input | 1 | Strobe: message fields are valid (coincides with stop_seen) |
| msg_hdr | input | 8 | Header byte of the message |
| ext_flag | input | 1 | Extension flag of an identification message |
| ce_value | input | 8 | Signed control-error value |
| chk_err | input | 1 | Message failed its checksum |
| foreign_obj | input | 1 | Foreign-object warning |
| power_en | output | 1 | Power signal enable for the inverter |
| probe_en | output | 1 | Detection probe enable |
| freq_cmd | output | FW | Inverter frequency command in kHz |

## Verification
- **Power and probe outputs:** these decode the state register. A message's verdict is therefore visible right after the edge that samples its strobe, and the bench samples it on the following falling edge.
- **Frequency command:** it moves exactly SETTLE edges after the control-error strobe. The bench checks the old value two cycles after the strobe and the new value two cycles past the settle delay.
- **Timeouts and restart:** a timeout drops power one edge after its counter reaches the limit. The restart gives probe_en RESTART+PROBE_GAP edges after power falls. These checks are taken a few cycles before and after the due edge, so a shifted limit or an off-by-several count is reported.

// File: rtl/wpt_seq_pkg.sv
package wpt_seq_pkg;

    typedef enum logic [2:0] {
        S_SEL_WAIT,
        S_SEL_PROBE,
        S_PING,
        S_ID_FIRST,
        S_ID_EXT,
        S_ID_OPT,
        S_XFER,
        S_OFF
    } phase_t;

    typedef enum logic [3:0] {
        K_SIG,
        K_EPT,
        K_CE,
        K_RP,
        K_CS,
        K_HOLD,
        K_PROP,
        K_ID,
        K_XID,
        K_CFG,
        K_RSV
    } msg_kind_t;

    localparam logic [7:0] HDR_SIG    = 8'h01;
    localparam logic [7:0] HDR_EPT    = 8'h02;
    localparam logic [7:0] HDR_CE     = 8'h03;
    localparam logic [7:0] HDR_RP     = 8'h04;
    localparam logic [7:0] HDR_CS     = 8'h05;
    localparam logic [7:0] HDR_HOLD   = 8'h06;
    localparam logic [7:0] HDR_PROP_A = 8'h18;
    localparam logic [7:0] HDR_PROP_B = 8'hF2;
    localparam logic [7:0] HDR_CFG    = 8'h51;
    localparam logic [7:0] HDR_ID     = 8'h71;
    localparam logic [7:0] HDR_XID    = 8'h81;

    function automatic logic is_optional(msg_kind_t k);
        return (k == K_HOLD) || (k == K_PROP) || (k == K_RSV);
    endfunction

    function automatic logic xfer_allowed(msg_kind_t k);
        return (k == K_CE) || (k == K_RP) || (k == K_CS) ||
               (k == K_EPT) || (k == K_PROP) || (k == K_RSV);
    endfunction

endpackage

// File: rtl/wpt_hdr_class.sv
module wpt_hdr_class
    import wpt_seq_pkg::*;
(
    input  logic [7:0] hdr,
    output msg_kind_t  kind
);

    always_comb begin
        unique case (hdr)
            HDR_SIG:    kind = K_SIG;
            HDR_EPT:    kind = K_EPT;
            HDR_CE:     kind = K_CE;
            HDR_RP:     kind = K_RP;
            HDR_CS:     kind = K_CS;
            HDR_HOLD:   kind = K_HOLD;
            HDR_PROP_A: kind = K_PROP;
            HDR_PROP_B: kind = K_PROP;
            HDR_CFG:    kind = K_CFG;
            HDR_ID:     kind = K_ID;
            HDR_XID:    kind = K_XID;
            default:    kind = K_RSV;
        endcase
    end

endmodule

// File: rtl/wpt_wait_timer.sv
module wpt_wait_timer #(
    parameter int LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic expired
);

    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (en && (cnt_q != LIM)) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign expired = (cnt_q == LIM);

endmodule

// File: rtl/wpt_freq_ctl.sv
module wpt_freq_ctl #(
    parameter int FW     = 8,
    parameter int F_MIN  = 110,
    parameter int F_MAX  = 205,
    parameter int F_PING = 175,
    parameter int F_STEP = 1,
    parameter int SETTLE = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic          load,
    input  logic [7:0]    ce_in,
    output logic [FW-1:0] freq_cmd
);

    localparam int TW = $clog2(SETTLE + 1);
    localparam int SW = FW + 10;
    localparam logic signed [SW-1:0] MIN_S  = SW'(F_MIN);
    localparam logic signed [SW-1:0] MAX_S  = SW'(F_MAX);
    localparam logic signed [SW-1:0] STEP_S = SW'(F_STEP);

    logic [TW-1:0]        wait_q;
    logic [7:0]           ce_q;
    logic [FW-1:0]        freq_q;
    logic signed [SW-1:0] cand;
    logic [FW-1:0]        freq_next;

    always_comb begin
        cand = $signed({{(SW-FW){1'b0}}, freq_q}) -
               ($signed({{(SW-8){ce_q[7]}}, ce_q}) * STEP_S);
        if (cand < MIN_S) begin
            freq_next = FW'(F_MIN);
        end else if (cand > MAX_S) begin
            freq_next = FW'(F_MAX);
        end else begin
            freq_next = cand[FW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            freq_q <= FW'(F_PING);
            wait_q <= '0;
            ce_q   <= '0;
        end else if (hold) begin
            freq_q <= FW'(F_PING);
            wait_q <= '0;
        end else if (load) begin
            ce_q   <= ce_in;
            wait_q <= TW'(SETTLE);
        end else if (wait_q != '0) begin
            wait_q <= wait_q - TW'(1);
            if (wait_q == TW'(1)) begin
                freq_q <= freq_next;
            end
        end
    end

    assign freq_cmd = freq_q;

endmodule

// File: rtl/wpt_phase_seq.sv
module wpt_phase_seq
    import wpt_seq_pkg::*;
#(
    parameter int FW        = 8,
    parameter int F_MIN     = 110,
    parameter int F_MAX     = 205,
    parameter int F_PING    = 175,
    parameter int F_STEP    = 1,
    parameter int PROBE_GAP = 62_500_000,
    parameter int PROBE_LEN = 1_250_000,
    parameter int RESP_TMO  = 2_500_000,
    parameter int CE_TMO    = 225_000_000,
    parameter int RP_TMO    = 375_000_000,
    parameter int SETTLE    = 625_000,
    parameter int RESTART   = 1_250_000,
    parameter int MAX_OPT   = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          probe_resp,
    input  logic          start_seen,
    input  logic          stop_seen,
    input  logic          msg_valid,
    input  logic [7:0]    msg_hdr,
    input  logic          ext_flag,
    input  logic [7:0]    ce_value,
    input  logic          chk_err,
    input  logic          foreign_obj,
    output logic          power_en,
    output logic          probe_en,
    output logic [FW-1:0] freq_cmd
);

    localparam int STG_A   = (PROBE_GAP > PROBE_LEN) ? PROBE_GAP : PROBE_LEN;
    localparam int STG_MAX = (STG_A > RESTART) ? STG_A : RESTART;
    localparam int SCW     = $clog2(STG_MAX + 1);
    localparam int OCW     = $clog2(MAX_OPT + 1);

    phase_t    state_q, state_d;
    msg_kind_t kind;

    logic [SCW-1:0] stage_q;
    logic [OCW-1:0] opt_q;
    logic           inflight_q;
    logic           rp_seen_q;

    logic good_msg, changing, ce_hit, rp_hit;
    logic resp_exp, ce_exp, rp_exp;
    logic resp_late, ce_late, rp_late;

    wpt_hdr_class u_cls (
        .hdr  (msg_hdr),
        .kind (kind)
    );

    assign good_msg = msg_valid & ~chk_err;
    assign changing = (state_d != state_q);
    assign ce_hit   = good_msg & (kind == K_CE);
    assign rp_hit   = good_msg & (kind == K_RP);

    wpt_wait_timer #(.LIMIT(RESP_TMO)) u_resp_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (changing | stop_seen),
        .en      (power_en),
        .expired (resp_exp)
    );

    wpt_wait_timer #(.LIMIT(CE_TMO)) u_ce_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (changing | ce_hit),
        .en      (power_en),
        .expired (ce_exp)
    );

    wpt_wait_timer #(.LIMIT(RP_TMO)) u_rp_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (changing),
        .en      (power_en),
        .expired (rp_exp)
    );

    assign resp_late = resp_exp & ~inflight_q & ~start_seen;
    assign ce_late   = ce_exp & ~inflight_q & ~start_seen;
    assign rp_late   = rp_exp & ~rp_seen_q;

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_SEL_WAIT: begin
                if (stage_q == SCW'(PROBE_GAP - 1)) state_d = S_SEL_PROBE;
            end
            S_SEL_PROBE: begin
                if (probe_resp) begin
                    state_d = S_PING;
                end else if (stage_q == SCW'(PROBE_LEN - 1)) begin
                    state_d = S_SEL_WAIT;
                end
            end
            S_PING: begin
                if (good_msg) begin
                    state_d = (kind == K_SIG) ? S_ID_FIRST : S_OFF;
                end else if (resp_late) begin
                    state_d = S_OFF;
                end
            end
            S_ID_FIRST: begin
                if (good_msg) begin
                    if (kind == K_ID) begin
                        state_d = ext_flag ? S_ID_EXT : S_ID_OPT;
                    end else begin
                        state_d = S_OFF;
                    end
                end else if (resp_late) begin
                    state_d = S_OFF;
                end
            end
            S_ID_EXT: begin
                if (good_msg) begin
                    state_d = (kind == K_XID) ? S_ID_OPT : S_OFF;
                end else if (resp_late) begin
                    state_d = S_OFF;
                end
            end
            S_ID_OPT: begin
                if (good_msg) begin
                    if (kind == K_CFG) begin
                        state_d = S_XFER;
                    end else if (!(is_optional(kind) && (opt_q != OCW'(MAX_OPT)))) begin
                        state_d = S_OFF;
                    end
                end else if (resp_late) begin
                    state_d = S_OFF;
                end
            end
            S_XFER: begin
                if (foreign_obj) begin
                    state_d = S_PING;
                end else if (good_msg && !xfer_allowed(kind)) begin
                    state_d = S_OFF;
                end else if ((ce_late && !ce_hit) || (rp_late && !rp_hit)) begin
                    state_d = S_OFF;
                end
            end
            S_OFF: begin
                if (stage_q == SCW'(RESTART - 1)) state_d = S_SEL_WAIT;
            end
            default: state_d = S_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_SEL_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    // per-phase counters and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q    <= '0;
            opt_q      <= '0;
            inflight_q <= 1'b0;
            rp_seen_q  <= 1'b0;
        end else begin
            if (changing) begin
                stage_q <= '0;
            end else if (stage_q != SCW'(STG_MAX)) begin
                stage_q <= stage_q + SCW'(1);
            end

            if (changing) begin
                opt_q <= '0;
            end else if ((state_q == S_ID_OPT) && good_msg && is_optional(kind)) begin
                opt_q <= opt_q + OCW'(1);
            end

            if (!power_en || stop_seen) begin
                inflight_q <= 1'b0;
            end else if (start_seen) begin
                inflight_q <= 1'b1;
            end

            if (changing) begin
                rp_seen_q <= 1'b0;
            end else if ((state_q == S_XFER) && rp_hit) begin
                rp_seen_q <= 1'b1;
            end
        end
    end

    // outputs decoded from the state
    always_comb begin
        power_en = 1'b0;
        probe_en = 1'b0;
        unique case (state_q)
            S_SEL_PROBE: probe_en = 1'b1;
            S_PING, S_ID_FIRST, S_ID_EXT, S_ID_OPT, S_XFER: power_en = 1'b1;
            default: ;
        endcase
    end

    wpt_freq_ctl #(
        .FW     (FW),
        .F_MIN  (F_MIN),
        .F_MAX  (F_MAX),
        .F_PING (F_PING),
        .F_STEP (F_STEP),
        .SETTLE (SETTLE)
    ) u_freq (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (state_d != S_XFER),
        .load     ((state_q == S_XFER) && ce_hit),
        .ce_in    (ce_value),
        .freq_cmd (freq_cmd)
    );

endmodule

// File: rtl/wpt_phase_seq_chk.sv
module wpt_phase_seq_chk
    import wpt_seq_pkg::*;
#(
    parameter int FW     = 8,
    parameter int F_MIN  = 110,
    parameter int F_MAX  = 205,
    parameter int F_PING = 175
) (
    input logic          clk,
    input logic          rst_n,
    input phase_t        state,
    input logic          power_en,
    input logic          probe_en,
    input logic [FW-1:0] freq_cmd,
    input logic          foreign_obj,
    input logic          msg_valid,
    input logic          chk_err,
    input logic [7:0]    msg_hdr
);

    a_r1_probe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(probe_en && power_en));

    a_r2_ping_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PING && msg_valid && !chk_err && msg_hdr != HDR_SIG) |=> !power_en);

    a_r5_fixed_point: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_XFER) |-> (freq_cmd == FW'(F_PING)));

    a_r8_freq_range: assert property (@(posedge clk) disable iff (!rst_n)
        (freq_cmd >= FW'(F_MIN)) && (freq_cmd <= FW'(F_MAX)));

    a_r9_fod_to_ping: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_XFER && foreign_obj) |=> (state == S_PING && freq_cmd == FW'(F_PING)));

    a_r12_drop_via_off: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(power_en) |-> (state == S_OFF));

endmodule

bind wpt_phase_seq wpt_phase_seq_chk #(
    .FW     (FW),
    .F_MIN  (F_MIN),
    .F_MAX  (F_MAX),
    .F_PING (F_PING)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .state       (state_q),
    .power_en    (power_en),
    .probe_en    (probe_en),
    .freq_cmd    (freq_cmd),
    .foreign_obj (foreign_obj),
    .msg_valid   (msg_valid),
    .chk_err     (chk_err),
    .msg_hdr     (msg_hdr)
);

// File: tb/wpt_phase_seq_bench.sv
module wpt_phase_seq_bench;

    localparam int GAP    = 8;
    localparam int PLEN   = 4;
    localparam int RESP   = 40;
    localparam int CET    = 60;
    localparam int RPT    = 120;
    localparam int SETL   = 5;
    localparam int RSTRT  = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       probe_resp = 1'b0;
    logic       start_seen = 1'b0;
    logic       stop_seen = 1'b0;
    logic       msg_valid = 1'b0;
    logic [7:0] msg_hdr = 8'h00;
    logic       ext_flag = 1'b0;
    logic [7:0] ce_value = 8'h00;
    logic       chk_err = 1'b0;
    logic       foreign_obj = 1'b0;
    logic       power_en, probe_en;
    logic [7:0] freq_cmd;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    wpt_phase_seq #(
        .PROBE_GAP (GAP), .PROBE_LEN (PLEN), .RESP_TMO (RESP),
        .CE_TMO (CET), .RP_TMO (RPT), .SETTLE (SETL), .RESTART (RSTRT)
    ) u_wpt_phase_seq (
        .clk (clk), .rst_n (rst_n), .probe_resp (probe_resp),
        .start_seen (start_seen), .stop_seen (stop_seen), .msg_valid (msg_valid),
        .msg_hdr (msg_hdr), .ext_flag (ext_flag), .ce_value (ce_value),
        .chk_err (chk_err), .foreign_obj (foreign_obj),
        .power_en (power_en), .probe_en (probe_en), .freq_cmd (freq_cmd)
    );

    // {phase 0=ping 1=id_first 2=id_opt 3=xfer, header, power expected}
    localparam int NV = 22;
    localparam logic [10:0] VEC [0:NV-1] = '{
        {2'd0, 8'h01, 1'b1}, {2'd0, 8'h71, 1'b0}, {2'd0, 8'h03, 1'b0},
        {2'd1, 8'h71, 1'b1}, {2'd1, 8'h51, 1'b0},
        {2'd2, 8'h51, 1'b1}, {2'd2, 8'h06, 1'b1}, {2'd2, 8'h18, 1'b1},
        {2'd2, 8'hF2, 1'b1}, {2'd2, 8'h37, 1'b1}, {2'd2, 8'h03, 1'b0},
        {2'd2, 8'h81, 1'b0},
        {2'd3, 8'h03, 1'b1}, {2'd3, 8'h04, 1'b1}, {2'd3, 8'h05, 1'b1},
        {2'd3, 8'h02, 1'b1}, {2'd3, 8'h18, 1'b1}, {2'd3, 8'h9A, 1'b1},
        {2'd3, 8'h01, 1'b0}, {2'd3, 8'h71, 1'b0}, {2'd3, 8'h06, 1'b0},
        {2'd3, 8'h51, 1'b0}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_bit(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic chk_val(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        probe_resp = 1'b0; start_seen = 1'b0; stop_seen = 1'b0; msg_valid = 1'b0;
        chk_err = 1'b0; foreign_obj = 1'b0; ext_flag = 1'b0; ce_value = 8'h00;
        tick(3);
        rst_n = 1'b1;
    endtask

    task automatic go_ping();
        probe_resp = 1'b1;
        for (int i = 0; i < 60 && !power_en; i++) tick(1);
        probe_resp = 1'b0;
    endtask

    task automatic send_msg(input logic [7:0] hdr, input logic ext,
                            input logic [7:0] ce, input logic bad);
        start_seen = 1'b1;
        tick(1);
        start_seen = 1'b0;
        tick(2);
        msg_valid = 1'b1; stop_seen = 1'b1; msg_hdr = hdr;
        ext_flag = ext; ce_value = ce; chk_err = bad;
        tick(1);
        msg_valid = 1'b0; stop_seen = 1'b0; ext_flag = 1'b0; chk_err = 1'b0;
    endtask

    task automatic go_phase(input int ph);
        do_reset();
        go_ping();
        if (ph >= 1) send_msg(8'h01, 1'b0, 8'h00, 1'b0);
        if (ph >= 2) send_msg(8'h71, 1'b0, 8'h00, 1'b0);
        if (ph == 3) send_msg(8'h51, 1'b0, 8'h00, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int pc;
        // reset state (R1, R5)
        do_reset();
        chk_bit("R1 reset power_en", power_en, 1'b0);
        chk_bit("R1 reset probe_en", probe_en, 1'b0);
        chk_val("R5 reset freq", freq_cmd, 8'd175);

        // vector table: header acceptance per phase (R2 R3 R4 R6)
        for (int v = 0; v < NV; v++) begin
            string tag;
            go_phase(int'(VEC[v][10:9]));
            send_msg(VEC[v][8:1], 1'b0, 8'h00, 1'b0);
            case (VEC[v][10:9])
                2'd0: tag = $sformatf("R2 ping hdr %h", VEC[v][8:1]);
                2'd1: tag = $sformatf("R3 id hdr %h", VEC[v][8:1]);
                2'd2: tag = $sformatf("R4 opt hdr %h", VEC[v][8:1]);
                default: tag = $sformatf("R6 xfer hdr %h", VEC[v][8:1]);
            endcase
            chk_bit(tag, power_en, VEC[v][0]);
        end

        // R1: probe cadence without response
        do_reset();
        pc = 0;
        for (int i = 0; i < 2 * (GAP + PLEN); i++) begin
            tick(1);
            if (probe_en) pc++;
            if (power_en) pc += 100;
        end
        chk_val("R1 probe cycles", 8'(pc), 8'(2 * PLEN));
        go_ping();
        chk_bit("R1 response enters ping", power_en, 1'b1);
        chk_val("R5 ping freq", freq_cmd, 8'd175);

        // R3: extension flag demands 0x81
        go_phase(1);
        send_msg(8'h71, 1'b1, 8'h00, 1'b0);
        chk_bit("R3 ext id accepted", power_en, 1'b1);
        send_msg(8'h51, 1'b0, 8'h00, 1'b0);
        chk_bit("R3 cfg without 0x81", power_en, 1'b0);
        go_phase(1);
        send_msg(8'h71, 1'b1, 8'h00, 1'b0);
        send_msg(8'h81, 1'b0, 8'h00, 1'b0);
        chk_bit("R3 0x81 accepted", power_en, 1'b1);
        chk_val("R5 id freq", freq_cmd, 8'd175);
        send_msg(8'h51, 1'b0, 8'h00, 1'b0);
        send_msg(8'h04, 1'b0, 8'h00, 1'b0);
        send_msg(8'h03, 1'b0, 8'd5, 1'b0);
        tick(SETL + 2);
        chk_val("R3 reached transfer", freq_cmd, 8'd170);

        // R4: seven optional messages allowed, eighth rejected
        go_phase(2);
        for (int i = 0; i < 7; i++) send_msg((i % 2 == 0) ? 8'h06 : 8'h44, 1'b0, 8'h00, 1'b0);
        chk_bit("R4 seven optional", power_en, 1'b1);
        send_msg(8'h51, 1'b0, 8'h00, 1'b0);
        send_msg(8'h04, 1'b0, 8'h00, 1'b0);
        send_msg(8'h03, 1'b0, 8'd1, 1'b0);
        tick(SETL + 2);
        chk_val("R4 cfg after seven", freq_cmd, 8'd174);
        go_phase(2);
        for (int i = 0; i < 8; i++) send_msg(8'h18, 1'b0, 8'h00, 1'b0);
        chk_bit("R4 eighth optional", power_en, 1'b0);

        // R8: settle delay and clamping; then R7 control-error timeout
        go_phase(3);
        send_msg(8'h04, 1'b0, 8'h00, 1'b0);
        send_msg(8'h03, 1'b0, 8'd10, 1'b0);
        tick(2);
        chk_val("R8 before settle", freq_cmd, 8'd175);
        tick(SETL);
        chk_val("R8 after settle", freq_cmd, 8'd165);
        send_msg(8'h03, 1'b0, 8'h80, 1'b0);
        tick(SETL + 2);
        chk_val("R8 clamp high", freq_cmd, 8'd205);
        send_msg(8'h03, 1'b0, 8'h7F, 1'b0);
        tick(SETL + 2);
        chk_val("R8 clamp low", freq_cmd, 8'd110);
        send_msg(8'h03, 1'b0, 8'hFD, 1'b0);
        tick(SETL + 2);
        chk_val("R8 negative step", freq_cmd, 8'd113);
        tick(45);
        chk_bit("R7 before ce timeout", power_en, 1'b1);
        tick(15);
        chk_bit("R7 after ce timeout", power_en, 1'b0);

        // R7: rectified-power timeout
        go_phase(3);
        for (int i = 0; i < 8; i++) begin
            send_msg(8'h03, 1'b0, 8'h00, 1'b0);
            tick(16);
            if (i == 4) chk_bit("R7 before rp timeout", power_en, 1'b1);
            if (i == 6) chk_bit("R7 after rp timeout", power_en, 1'b0);
        end

        // R9: foreign object returns to ping
        go_phase(3);
        send_msg(8'h04, 1'b0, 8'h00, 1'b0);
        send_msg(8'h03, 1'b0, 8'd20, 1'b0);
        tick(SETL + 2);
        chk_val("R9 pre fod freq", freq_cmd, 8'd155);
        foreign_obj = 1'b1;
        tick(1);
        foreign_obj = 1'b0;
        chk_val("R9 fod freq", freq_cmd, 8'd175);
        chk_bit("R9 fod power", power_en, 1'b1);
        send_msg(8'h01, 1'b0, 8'h00, 1'b0);
        chk_bit("R9 ping after fod", power_en, 1'b1);
        send_msg(8'h71, 1'b0, 8'h00, 1'b0);
        chk_bit("R9 id after fod", power_en, 1'b1);

        // R10: missing start bit in ping and identification
        do_reset();
        go_ping();
        tick(RESP - 2);
        chk_bit("R10 ping before timeout", power_en, 1'b1);
        tick(6);
        chk_bit("R10 ping after timeout", power_en, 1'b0);
        go_phase(1);
        tick(RESP - 2);
        chk_bit("R10 id before timeout", power_en, 1'b1);
        tick(6);
        chk_bit("R10 id after timeout", power_en, 1'b0);

        // R11: checksum-error messages ignored
        do_reset();
        go_ping();
        send_msg(8'h71, 1'b0, 8'h00, 1'b1);
        chk_bit("R11 bad msg in ping", power_en, 1'b1);
        send_msg(8'h01, 1'b0, 8'h00, 1'b0);
        send_msg(8'h03, 1'b0, 8'h00, 1'b1);
        chk_bit("R11 bad msg in id", power_en, 1'b1);
        send_msg(8'h71, 1'b0, 8'h00, 1'b0);
        chk_bit("R11 order kept", power_en, 1'b1);

        // R12: restart delay then selection
        do_reset();
        go_ping();
        send_msg(8'h03, 1'b0, 8'h00, 1'b0);
        chk_bit("R12 power removed", power_en, 1'b0);
        tick(RSTRT + GAP - 2);
        chk_bit("R12 probe held off", probe_en, 1'b0);
        tick(3);
        chk_bit("R12 probe resumes", probe_en, 1'b1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule